// File: doc/BRIEF.md
# Microwire EEPROM Host Controller

This block is a bus master for a three-wire serial EEPROM. It drives chip select, serial clock and serial data out, and it samples the device's serial data return line. A single command port accepts one of eight operations with an address, write data and a burst length. The block builds the serial instruction for the selected memory organization (16-bit or 8-bit words), clocks it out and then finishes the operation. Read data comes back as whole words with a one-cycle valid strobe. A done pulse, with an error flag beside it, ends every command.

The serial clock is a divided copy of the system clock, and each half period lasts a set number of cycles. Reads throw away the leading dummy zero that the device sends. A burst keeps clocking for as many words as were asked for, and address wrap is left to the device. Program operations (write, erase, erase-all, write-all) release chip select for a minimum low time after the instruction. Chip select then goes high again and the return line is polled for the ready level, with a timeout. The block keeps a copy of the device's write-enable latch, so a program command that the device would ignore is refused at once.

Top module: `uwire_host`

## Requirements
- R1: Every instruction is sent MSB first as a 1 start bit, a two-bit opcode and an address field, followed by data for write and write-all. The opcodes are read 10, write 01, erase 11 and 00 for the four special commands. The address field is AW bits wide in 16-bit mode and AW+1 bits wide in 8-bit mode (`org_x8`=1). The special commands carry a code in its top two bits, with zeros below: enable 11, disable 00, erase-all 10, write-all 01. The data field is 16 bits wide in 16-bit mode and 8 bits wide in 8-bit mode.
- R2: `sk` is high only while `cs` is high. Each high phase and each low phase of `sk` lasts DIV_HALF clock cycles, and `di` never changes while `sk` is high.
- R3: A read skips the first returned bit and assembles each word MSB first. It pulses `rd_valid` for one cycle per word. In 8-bit mode the byte sits in `rd_data[7:0]` and the upper byte is zero.
- R4: A burst read (op 1) returns `cmd_len`+1 consecutive words within a single chip-select frame. No dummy bit is expected between words.
- R5: After a program instruction, `cs` stays low for CSL_HALF half periods and then rises. The block polls `do_in` once per half period, and when it reads high the block drops `cs` and reports done without error.
- R6: If `do_in` stays low for POLL_MAX polled half periods, the block drops `cs` and reports done with `err` set.
- R7: A program command (op 2, 3, 6 or 7) issued after reset or after a disable is refused. `done` and `err` pulse in the cycle after acceptance, and `cs` never rises.
- R8: Enable (op 4) and disable (op 5) send their instruction and finish without polling. They set and clear the write-enable copy.
- R9: `cmd_op` codes are: 0 read, 1 burst read, 2 write, 3 erase, 4 enable, 5 disable, 6 erase-all, 7 write-all. A command is taken when `cmd_valid` is high and `busy` is low. `done` is a one-cycle pulse, and `err` is only high together with `done`.
- R10: During and after reset, `cs`, `sk`, `di`, `busy`, `done`, `err` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Operation code (R9) |
| cmd_addr | input | AW+1 | Word or byte address |
| cmd_wdata | input | 16 | Write data (low byte in 8-bit mode) |
| cmd_len | input | LEN_W | Burst length minus one |
| org_x8 | input | 1 | 1 selects 8-bit organization |
| busy | output | 1 | A command is in progress |
| done | output | 1 | Command finished pulse |
| err | output | 1 | Refused or timed out, with done |
| rd_valid | output | 1 | Read word strobe |
| rd_data | output | 16 | Read word |
| cs | output | 1 | Chip select to the device |
| sk | output | 1 | Serial clock to the device |
| di | output | 1 | Serial data to the device |
| do_in | input | 1 | Serial data and status from the device |

## Verification
The strobe for the last word of a read falls in the same cycle as the drop of chip select at the end of the shift phase. The bench covers this case with single reads at every address and with bursts that cross the address wrap. It judges the result by the word count and the values each read returns. A refused program command completes in the cycle after acceptance, with no edge at all on chip select. The bench provokes this directly after a disable and judges it by counting the device model's select frames.

// File: rtl/uwire_host.sv
module uwire_host #(
  parameter int AW       = 10,
  parameter int DIV_HALF = 42,
  parameter int CSL_HALF = 2,
  parameter int POLL_MAX = 200000,
  parameter int LEN_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [AW:0]      cmd_addr,
  input  logic [15:0]      cmd_wdata,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             org_x8,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             rd_valid,
  output logic [15:0]      rd_data,
  output logic             cs,
  output logic             sk,
  output logic             di,
  input  logic             do_in
);
  localparam int TXW  = AW + 20;
  localparam int NBW  = $clog2(AW + 20 + 16 * (2 ** LEN_W));
  localparam int DIVW = $clog2(DIV_HALF + 1);
  localparam int TW   = $clog2(POLL_MAX + CSL_HALF + 1);

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_GAP, S_POLL, S_TAIL} st_t;
  st_t st;

  logic           x8_q, rd_q, prog_q, we_en, err_q;
  logic [TXW-1:0] tx_sr;
  logic [NBW-1:0] bitn, nb_q, fb_q;
  logic [3:0]     wbit;
  logic [14:0]    rd_sr;
  logic [DIVW-1:0] div;
  logic [TW-1:0]  cnt;

  wire tick = (div == DIVW'(DIV_HALF - 1));
  wire [15:0] samp = {rd_sr, do_in};
  wire [3:0] wlast = x8_q ? 4'd7 : 4'd15;

  wire is_rd    = (cmd_op == 3'd0) || (cmd_op == 3'd1);
  wire is_prog  = (cmd_op == 3'd2) || (cmd_op == 3'd3) || (cmd_op == 3'd6) || (cmd_op == 3'd7);
  wire has_data = (cmd_op == 3'd2) || (cmd_op == 3'd7);
  wire special  = cmd_op[2];

  logic [1:0] opc, code;
  always_comb begin
    unique case (cmd_op)
      3'd0, 3'd1: opc = 2'b10;
      3'd2:       opc = 2'b01;
      3'd3:       opc = 2'b11;
      default:    opc = 2'b00;
    endcase
    unique case (cmd_op[1:0])
      2'd0:    code = 2'b11;
      2'd1:    code = 2'b00;
      2'd2:    code = 2'b10;
      default: code = 2'b01;
    endcase
  end

  wire [AW-1:0]  a16 = special ? {code, {(AW-2){1'b0}}} : cmd_addr[AW-1:0];
  wire [AW:0]    a8  = special ? {code, {(AW-1){1'b0}}} : cmd_addr;
  wire [15:0]    wd  = has_data ? cmd_wdata : 16'h0000;
  wire [TXW-1:0] frame_c = org_x8 ? {1'b1, opc, a8, wd[7:0], 8'h00}
                                  : {1'b1, opc, a16, wd, 1'b0};

  wire [NBW-1:0] fb_c = org_x8 ? NBW'(AW + 4) : NBW'(AW + 3);
  wire [NBW-1:0] dw_c = org_x8 ? NBW'(8) : NBW'(16);
  wire [NBW-1:0] nw_c = (cmd_op == 3'd1) ? NBW'(cmd_len) + NBW'(1) : NBW'(1);
  wire [NBW-1:0] nb_c = fb_c + (has_data ? dw_c : '0) + (is_rd ? nw_c * dw_c : '0);

  assign busy = (st != S_IDLE);
  assign di   = tx_sr[TXW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cs <= 1'b0; sk <= 1'b0; tx_sr <= '0;
      done <= 1'b0; err <= 1'b0; rd_valid <= 1'b0; rd_data <= '0;
      x8_q <= 1'b0; rd_q <= 1'b0; prog_q <= 1'b0; we_en <= 1'b0; err_q <= 1'b0;
      bitn <= '0; nb_q <= '0; fb_q <= '0; wbit <= '0; rd_sr <= '0;
      div <= '0; cnt <= '0;
    end else begin
      done <= 1'b0; err <= 1'b0; rd_valid <= 1'b0;
      div <= (st == S_IDLE || tick) ? '0 : div + DIVW'(1);
      unique case (st)
        S_IDLE: if (cmd_valid) begin
          if (is_prog && !we_en) begin
            done <= 1'b1; err <= 1'b1;
          end else begin
            st <= S_SHIFT; cs <= 1'b1; sk <= 1'b0; tx_sr <= frame_c;
            x8_q <= org_x8; rd_q <= is_rd; prog_q <= is_prog;
            nb_q <= nb_c; fb_q <= fb_c; bitn <= '0; wbit <= '0; err_q <= 1'b0;
            if (cmd_op == 3'd4) we_en <= 1'b1;
            if (cmd_op == 3'd5) we_en <= 1'b0;
          end
        end
        S_SHIFT: if (tick) begin
          if (!sk) sk <= 1'b1;
          else begin
            sk <= 1'b0;
            tx_sr <= tx_sr << 1;
            bitn <= bitn + NBW'(1);
            if (rd_q && bitn >= fb_q) begin
              rd_sr <= samp[14:0];
              if (wbit == wlast) begin
                wbit <= '0;
                rd_valid <= 1'b1;
                rd_data <= x8_q ? {8'h00, samp[7:0]} : samp;
              end else wbit <= wbit + 4'd1;
            end
            if (bitn == nb_q - NBW'(1)) begin
              cs <= 1'b0; cnt <= '0;
              st <= prog_q ? S_GAP : S_TAIL;
            end
          end
        end
        S_GAP: if (tick) begin
          if (cnt == TW'(CSL_HALF - 1)) begin
            cs <= 1'b1; cnt <= '0; st <= S_POLL;
          end else cnt <= cnt + TW'(1);
        end
        S_POLL: if (tick) begin
          if (do_in) begin
            cs <= 1'b0; cnt <= '0; st <= S_TAIL;
          end else if (cnt == TW'(POLL_MAX - 1)) begin
            cs <= 1'b0; cnt <= '0; err_q <= 1'b1; st <= S_TAIL;
          end else cnt <= cnt + TW'(1);
        end
        S_TAIL: if (tick) begin
          if (cnt == TW'(CSL_HALF - 1)) begin
            st <= S_IDLE; done <= 1'b1; err <= err_q; cnt <= '0;
          end else cnt <= cnt + TW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_sk_needs_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !sk);
  p_di_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sk && $past(sk)) |-> $stable(di));
  p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  p_word_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cs));
  p_done_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cs);
endmodule

// File: tb/uwire_host_tb.sv
module uwire_host_tb_top;
  localparam int AW = 4, DH = 2, CSL = 2, PM = 40, LW = 5, BUSY_CYC = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [AW:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic [LW-1:0] cmd_len = '0;
  logic x8 = 1'b0;
  logic busy, done, err, rd_valid, cs, sk, di;
  logic [15:0] rd_data;
  logic do_in = 1'b1;

  uwire_host #(.AW(AW), .DIV_HALF(DH), .CSL_HALF(CSL), .POLL_MAX(PM), .LEN_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .cmd_len(cmd_len), .org_x8(x8), .busy(busy), .done(done),
    .err(err), .rd_valid(rd_valid), .rd_data(rd_data), .cs(cs), .sk(sk), .di(di), .do_in(do_in));

  int n_chk = 0, n_bad = 0;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // device model
  logic [7:0] mem8 [0:31];
  int phase = 0, bcnt = 0, addr = 0, wdv = 0, ra = 0, bc = 0, frames = 0, busy_cnt = 0;
  int hi_run = 0, bad_w = 0, bad_di = 0, bad_cs = 0;
  logic [1:0] sop = '0;
  logic pcs = 1'b0, psk = 1'b0, pdi = 1'b0, swe = 1'b0, stuck = 1'b0, rdb = 1'b0;

  function automatic int awm(); return x8 ? AW + 1 : AW; endfunction
  function automatic int dwm(); return x8 ? 8 : 16; endfunction
  function automatic int depth(); return x8 ? 32 : 16; endfunction
  function automatic logic [15:0] word_at(input int a);
    return x8 ? {8'h00, mem8[a]} : {mem8[2*a], mem8[2*a+1]};
  endfunction
  task automatic put(input int a, input logic [15:0] v);
    if (x8) mem8[a] = v[7:0];
    else begin mem8[2*a] = v[15:8]; mem8[2*a+1] = v[7:0]; end
  endtask

  always @(posedge clk) begin
    logic [15:0] w;
    int cd;
    if (sk && !cs) bad_cs++;
    if (sk) begin
      hi_run++;
      if (psk && di !== pdi) bad_di++;
    end else if (psk) begin
      if (hi_run != DH) bad_w++;
      hi_run = 0;
    end
    if (busy_cnt > 0) busy_cnt--;
    if (cs && !pcs) begin phase = 0; bcnt = 0; frames++; end
    if (cs && sk && !psk) begin
      case (phase)
        0: if (di) begin phase = 1; bcnt = 0; end
        1: begin sop = {sop[0], di}; bcnt++; if (bcnt == 2) begin phase = 2; bcnt = 0; addr = 0; end end
        2: begin
          addr = addr * 2 + int'(di); bcnt++;
          if (bcnt == awm()) begin
            cd = addr >> (awm() - 2);
            if (sop == 2'b10) begin phase = 4; rdb = 1'b0; ra = addr; bc = 0; end
            else if (sop == 2'b01 || (sop == 2'b00 && cd == 1)) begin phase = 3; bcnt = 0; wdv = 0; end
            else phase = 5;
          end
        end
        3: begin wdv = wdv * 2 + int'(di); bcnt++; if (bcnt == dwm()) phase = 5; end
        4: begin
          w = word_at(ra);
          rdb = w[dwm() - 1 - bc];
          bc++;
          if (bc == dwm()) begin bc = 0; ra = (ra + 1) % depth(); end
        end
        default: ;
      endcase
    end
    if (!cs && pcs && phase == 5) begin
      cd = addr >> (awm() - 2);
      phase = 6;
      if (sop == 2'b01 && swe) begin put(addr, 16'(wdv)); busy_cnt = BUSY_CYC; end
      else if (sop == 2'b11 && swe) begin put(addr, 16'hFFFF); busy_cnt = BUSY_CYC; end
      else if (sop == 2'b00) begin
        if (cd == 3) swe = 1'b1;
        else if (cd == 0) swe = 1'b0;
        else if (swe) begin
          for (int i = 0; i < depth(); i++) put(i, (cd == 2) ? 16'hFFFF : 16'(wdv));
          busy_cnt = BUSY_CYC;
        end
      end
    end
    do_in <= (cs && phase == 4) ? rdb : ((stuck || busy_cnt > 0) ? 1'b0 : 1'b1);
    pcs = cs; psk = sk; pdi = di;
  end

  logic [15:0] got [0:63];
  int nw = 0;
  logic last_err = 1'b0;

  task automatic run(input logic [2:0] op, input int a, input logic [15:0] wd, input int len);
    @(negedge clk);
    cmd_op = op; cmd_addr = (AW+1)'(a); cmd_wdata = wd; cmd_len = LW'(len); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; nw = 0;
    forever begin
      if (rd_valid && nw < 64) begin got[nw] = rd_data; nw++; end
      if (done) break;
      @(negedge clk);
    end
    last_err = err;
  endtask

  function automatic logic [15:0] pat(input int a);
    return x8 ? {8'h00, 8'((a * 29) ^ 8'h6B)} : 16'((a * 16'h1357) ^ 16'hA5C3);
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    summary();
  end

  initial begin
    int f0, bad;
    for (int i = 0; i < 32; i++) mem8[i] = 8'h00;
    repeat (4) @(negedge clk);
    chk("R10 cs", cs, 0); chk("R10 sk", sk, 0); chk("R10 di", di, 0);
    chk("R10 busy", busy, 0); chk("R10 done", done, 0); chk("R10 err", err, 0);
    chk("R10 rd_valid", rd_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    f0 = frames; run(3'd2, 3, 16'h1111, 0);
    chk("R7 refused write err", last_err, 1); chk("R7 no frame", frames, f0);
    chk("R7 memory untouched", word_at(3), 0);

    f0 = frames; run(3'd4, 0, 0, 0);
    chk("R8 enable err", last_err, 0); chk("R8 enable one frame", frames, f0 + 1);
    chk("R1 enable code seen", swe, 1);

    for (int a = 0; a < 16; a++) begin
      f0 = frames; run(3'd2, a, pat(a), 0);
      chk("R5 write err", last_err, 0); chk("R5 frame then poll", frames, f0 + 2);
      chk("R5 ready awaited", busy_cnt, 0); chk("R1 word stored", word_at(a), pat(a));
    end
    for (int a = 0; a < 16; a++) begin
      f0 = frames; run(3'd0, a, 0, 0);
      chk("R3 one word", nw, 1); chk("R3 read value", got[0], pat(a));
      chk("R9 read no poll", frames, f0 + 1);
    end
    run(3'd1, 12, 0, 7);
    chk("R4 burst count", nw, 8);
    for (int i = 0; i < 8; i++) chk("R4 burst wrap word", got[i], pat((12 + i) % 16));

    run(3'd3, 5, 0, 0); chk("R5 erase err", last_err, 0);
    run(3'd0, 5, 0, 0); chk("R1 erased word", got[0], 16'hFFFF);

    stuck = 1'b1; run(3'd2, 7, 16'h1234, 0); stuck = 1'b0;
    chk("R6 timeout err", last_err, 1);
    run(3'd0, 7, 0, 0); chk("R6 data still stored", got[0], 16'h1234);

    run(3'd7, 0, 16'h5AA5, 0); chk("R5 write-all err", last_err, 0);
    bad = 0; for (int i = 0; i < 16; i++) if (word_at(i) !== 16'h5AA5) bad++;
    chk("R1 write-all all words", bad, 0);
    run(3'd6, 0, 0, 0);
    run(3'd1, 0, 0, 15); chk("R4 full burst count", nw, 16);
    bad = 0; for (int i = 0; i < 16; i++) if (got[i] !== 16'hFFFF) bad++;
    chk("R1 erase-all read back", bad, 0);

    f0 = frames; run(3'd5, 0, 0, 0);
    chk("R8 disable err", last_err, 0); chk("R8 disable seen", swe, 0);
    f0 = frames; run(3'd3, 2, 0, 0);
    chk("R7 refused erase err", last_err, 1); chk("R7 refused erase no frame", frames, f0);

    x8 = 1'b1;
    for (int i = 0; i < 32; i++) mem8[i] = 8'h00;
    run(3'd4, 0, 0, 0); chk("R8 enable x8", swe, 1);
    for (int a = 0; a < 32; a++) begin
      run(3'd2, a, pat(a) | 16'hC300, 0);
      chk("R5 x8 write err", last_err, 0); chk("R1 x8 byte stored", word_at(a), pat(a));
    end
    for (int a = 0; a < 32; a++) begin
      run(3'd0, a, 0, 0);
      chk("R3 x8 read value upper zero", got[0], pat(a));
    end
    run(3'd1, 29, 0, 5);
    chk("R4 x8 burst count", nw, 6);
    for (int i = 0; i < 6; i++) chk("R4 x8 burst wrap", got[i], pat((29 + i) % 32));

    chk("R2 sk high width", bad_w, 0);
    chk("R2 di moved while sk high", bad_di, 0);
    chk("R2 sk without cs", bad_cs, 0);
    summary();
  end
endmodule